// File: doc/BRIEF.md
# Floating-point status and control register unit

This block keeps the floating-point status and control state for a scalar floating-point pipeline and carries out every command that manipulates that state directly. The state is a 64-bit image split into sixteen 4-bit fields. Field f occupies bits 4f+3..4f. The lower word (fields 0..7) holds the sticky exception flags, the two summary flags, the result class, the exception enables, the non-IEEE mode bit and the binary rounding mode. The upper word holds only a 3-bit decimal rounding mode at bits 34:32. All other upper bits read as zero.

Each command takes one clock. Read-type commands capture the image as it stood before the command and, in the same edge, write the modified state back. The two summary flags are never stored from a command. After every update they are rebuilt from the flags and enables. The overall exception flag is raised whenever an update turns on an exception flag that was clear. Arithmetic exception generation belongs to the execution units and is not part of this block.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, `fpscr_o`, `rd_data_o`, `crf_o` and `inval_o` are all zero.
- R2: Command 1 (field to condition) takes `field_i` = k and selects nibble n = 7 − k, at bits 4n+3..4n of the lower word. That nibble appears on `crf_o` one cycle later. In the same edge, only the sticky exception bits of that nibble are cleared (mask 0x9FF80700 within the lower word). All other bits are kept.
- R3: Command 2 clears and command 3 sets lower-word bit 31 − `bit_i`. A clear aimed at bit 30 or 29 is ignored. A set aimed at bit 30, 29 or 2 is ignored.
- R4: Any update that turns one of bits 28..19 or 10..8 from 0 to 1 also sets bit 31 (overall exception flag).
- R5: The lower-word layout is: 31 overall flag, 30 enabled-exception summary, 29 invalid summary, 28..25 overflow/underflow/divide-by-zero/inexact flags, 24..19 and 10..8 invalid-operation flags, 7..3 enables (invalid, overflow, underflow, divide-by-zero, inexact), 2 non-IEEE mode, 1:0 rounding mode. After every update:
  - Bit 29 equals the OR of the invalid-operation flags.
  - Bit 30 equals (29&7)|(28&6)|(27&5)|(26&4)|(25&3).
- R6: Command 5 (immediate field write) computes sh = 8·`w_i` + 7 − `field_i` and writes `imm_i` into bits 4sh+3..4sh of the image, touching no other field. Bits 63:35 stay zero, so an immediate into field 8 keeps only its low 3 bits as the decimal rounding mode.
- R7: Command 4 (masked write) copies `src_i` into every field whose bit is set in the field mask:
  - With `l_i` = 0, the mask is `flm_i` shifted left by 8·`w_i`.
  - With `l_i` = 1, all 16 fields are written when `ext_en_i` is 1, otherwise fields 0..7.
  - Bit 11 always stays zero.
- R8: Command 4 or 5 with `w_i` = 1 while `ext_en_i` = 0 leaves the state unchanged. It raises `inval_o` for exactly one cycle.
- R9: Command 7 returns the full pre-command image on `rd_data_o` and clears enables 7..3.
- R10: Command 8 (source) and command 9 (immediate) return the pre-command image ANDed with 0x0000_0007_0000_00FF. They then replace bits 1:0 with `src_i[1:0]` (command 8) or `imm_i[1:0]` (command 9), changing nothing else.
- R11: Command 6 returns the full image on `rd_data_o` without changing state. `rd_data_o` holds its value until the next read command.
- R12: Command 0 and codes 10..15 change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 4 | Command code |
| field_i | input | 3 | Field selector for field-to-condition and immediate write |
| bit_i | input | 5 | Bit selector for bit set/clear |
| flm_i | input | 8 | Field mask for masked write |
| l_i | input | 1 | Write all fields |
| w_i | input | 1 | Upper-word select |
| imm_i | input | 4 | Immediate value |
| src_i | input | 64 | Source doubleword |
| ext_en_i | input | 1 | Upper-word field extension supported |
| fpscr_o | output | 32 | Lower word of the state |
| rd_data_o | output | 64 | Result of the last read command |
| crf_o | output | 4 | Result of the last field-to-condition command |
| inval_o | output | 1 | Invalid-form pulse |

## Verification
Read commands return a pre-command snapshot and commit a rewrite of the same state at the same edge. The bench therefore runs the rounding-mode and enable-clearing reads against states whose rounding mode and enables are known. It judges `rd_data_o` against the old image and `fpscr_o` against the new one in the same sample. A second overlap is that a flag-raising update and the summary rebuild land in one edge. This is provoked by single-bit sets and immediate writes that raise a flag under a set or clear enable, and judged by the FX, VX and FEX bits of the very next sample.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int IMG_W   = 64;
  localparam int N_FLD   = 16;
  localparam int FLD_W   = IMG_W / N_FLD;
  localparam int MAIN_W  = 32;

  typedef enum logic [3:0] {
    CMD_NOP      = 4'd0,
    CMD_FLD2CR   = 4'd1,
    CMD_BCLR     = 4'd2,
    CMD_BSET     = 4'd3,
    CMD_WMASK    = 4'd4,
    CMD_WIMM     = 4'd5,
    CMD_RD_ALL   = 4'd6,
    CMD_RD_CLREN = 4'd7,
    CMD_RD_RN    = 4'd8,
    CMD_RD_RNI   = 4'd9
  } fpsc_cmd_e;

  localparam int B_FX  = 31;
  localparam int B_FEX = 30;
  localparam int B_VX  = 29;
  localparam int B_VE  = 7;
  localparam int B_NI  = 2;

  localparam logic [MAIN_W-1:0] STICKY_M = 32'h9FF8_0700;
  localparam logic [MAIN_W-1:0] RISE_M   = 32'h1FF8_0700;
  localparam logic [MAIN_W-1:0] VXSUB_M  = 32'h01F8_0700;
  localparam logic [MAIN_W-1:0] SUMM_M   = 32'h6000_0000;
  localparam logic [MAIN_W-1:0] ENA_M    = 32'h0000_00F8;
  localparam logic [MAIN_W-1:0] RN_M     = 32'h0000_0003;
  localparam logic [IMG_W-1:0]  LITE_M   = 64'h0000_0007_0000_00FF;
  localparam logic [IMG_W-1:0]  STORE_M  = 64'h0000_0007_9FFF_F7FF;
endpackage

// File: rtl/fpsc_decode.sv
module fpsc_decode
  import fpsc_pkg::*;
#(
  parameter int NF = N_FLD,
  parameter int IW = IMG_W
) (
  input  fpsc_cmd_e       cmd_i,
  input  logic [2:0]      field_i,
  input  logic [4:0]      bit_i,
  input  logic [7:0]      flm_i,
  input  logic            l_i,
  input  logic            w_i,
  input  logic [3:0]      imm_i,
  input  logic [IW-1:0]   src_i,
  input  logic            ext_en_i,
  input  logic [IW-1:0]   cur_i,
  output logic            wr_en_o,
  output logic [NF-1:0]   fmask_o,
  output logic [IW-1:0]   fkeep_o,
  output logic [IW-1:0]   bmask_o,
  output logic [IW-1:0]   wval_o,
  output logic            rd_en_o,
  output logic [IW-1:0]   rd_val_o,
  output logic            cr_en_o,
  output logic [3:0]      cr_val_o,
  output logic            inval_o
);
  localparam logic [NF-1:0] BASE_M = NF'((1 << (NF / 2)) - 1);

  logic [2:0] nib;
  logic [3:0] sh;
  logic [4:0] bpos;
  logic       wide_bad;

  assign nib      = 3'd7 - field_i;
  assign sh       = {w_i, 3'b111} - {1'b0, field_i};
  assign bpos     = 5'd31 - bit_i;
  assign wide_bad = w_i & ~ext_en_i;

  always_comb begin
    wr_en_o  = 1'b0;
    fmask_o  = '0;
    fkeep_o  = '1;
    bmask_o  = '0;
    wval_o   = '0;
    rd_en_o  = 1'b0;
    rd_val_o = '0;
    cr_en_o  = 1'b0;
    cr_val_o = '0;
    inval_o  = 1'b0;
    case (cmd_i)
      CMD_FLD2CR: begin
        cr_en_o  = 1'b1;
        cr_val_o = cur_i[{nib, 2'b00} +: 4];
        wr_en_o  = 1'b1;
        fmask_o  = NF'(1) << nib;
        fkeep_o  = {{(IW-MAIN_W){1'b0}}, STICKY_M};
      end
      CMD_BCLR: begin
        if (bpos != 5'(B_FEX) && bpos != 5'(B_VX)) begin
          wr_en_o = 1'b1;
          bmask_o = IW'(1) << bpos;
        end
      end
      CMD_BSET: begin
        if (bpos != 5'(B_FEX) && bpos != 5'(B_VX) && bpos != 5'(B_NI)) begin
          wr_en_o = 1'b1;
          bmask_o = IW'(1) << bpos;
          wval_o  = '1;
        end
      end
      CMD_WMASK: begin
        if (wide_bad) inval_o = 1'b1;
        else begin
          wr_en_o = 1'b1;
          wval_o  = src_i;
          if (l_i) fmask_o = ext_en_i ? '1 : BASE_M;
          else     fmask_o = NF'(flm_i) << {w_i, 3'b000};
        end
      end
      CMD_WIMM: begin
        if (wide_bad) inval_o = 1'b1;
        else begin
          wr_en_o = 1'b1;
          fmask_o = NF'(1) << sh;
          wval_o  = IW'(imm_i) << {sh, 2'b00};
        end
      end
      CMD_RD_ALL: begin
        rd_en_o  = 1'b1;
        rd_val_o = cur_i;
      end
      CMD_RD_CLREN: begin
        rd_en_o  = 1'b1;
        rd_val_o = cur_i;
        wr_en_o  = 1'b1;
        bmask_o  = IW'(ENA_M);
      end
      CMD_RD_RN, CMD_RD_RNI: begin
        rd_en_o  = 1'b1;
        rd_val_o = cur_i & LITE_M;
        wr_en_o  = 1'b1;
        bmask_o  = IW'(RN_M);
        wval_o   = (cmd_i == CMD_RD_RN) ? src_i : IW'(imm_i[1:0]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpsc_summary.sv
module fpsc_summary
  import fpsc_pkg::*;
(
  input  logic [MAIN_W-1:0] main_i,
  output logic [MAIN_W-1:0] main_o
);
  logic vx, fex;

  assign vx  = |(main_i & VXSUB_M);
  // overflow..inexact flags (28:25) pair with their enables (6:3)
  assign fex = (vx & main_i[B_VE]) | (|(main_i[28:25] & main_i[6:3]));
  assign main_o = {main_i[B_FX], fex, vx, main_i[28:0]};
endmodule

// File: rtl/fpsc_merge.sv
module fpsc_merge
  import fpsc_pkg::*;
#(
  parameter int NF = N_FLD,
  parameter int IW = IMG_W
) (
  input  logic [IW-1:0] cur_i,
  input  logic          wr_en_i,
  input  logic [NF-1:0] fmask_i,
  input  logic [IW-1:0] fkeep_i,
  input  logic [IW-1:0] bmask_i,
  input  logic [IW-1:0] wval_i,
  output logic [IW-1:0] nxt_o
);
  localparam int FW = IW / NF;

  logic [IW-1:0]     fld_bits, bits, staged;
  logic [MAIN_W-1:0] raised, sum_out;
  logic              rise;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fld_bits[g*FW +: FW] = {FW{fmask_i[g]}};
  end

  assign bits   = ((fld_bits & fkeep_i) | bmask_i) & STORE_M;
  assign staged = wr_en_i ? ((cur_i & ~bits) | (wval_i & bits)) : cur_i;
  assign rise   = |(staged[MAIN_W-1:0] & ~cur_i[MAIN_W-1:0] & RISE_M);
  assign raised = staged[MAIN_W-1:0] | (MAIN_W'(rise) << B_FX);

  fpsc_summary u_sum (
    .main_i (raised),
    .main_o (sum_out)
  );

  assign nxt_o = {staged[IW-1:MAIN_W], sum_out};
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fpsc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  cmd_i,
  input  logic [2:0]  field_i,
  input  logic [4:0]  bit_i,
  input  logic [7:0]  flm_i,
  input  logic        l_i,
  input  logic        w_i,
  input  logic [3:0]  imm_i,
  input  logic [63:0] src_i,
  input  logic        ext_en_i,
  output logic [31:0] fpscr_o,
  output logic [63:0] rd_data_o,
  output logic [3:0]  crf_o,
  output logic        inval_o
);
  fpsc_cmd_e          cmd;
  logic [IMG_W-1:0]   img_q, nxt, fkeep, bmask, wval, rd_val, rd_q;
  logic [N_FLD-1:0]   fmask;
  logic               wr_en, rd_en, cr_en, inval, inval_q;
  logic [3:0]         cr_val, crf_q;

  assign cmd = fpsc_cmd_e'(cmd_i);

  fpsc_decode #(.NF(N_FLD), .IW(IMG_W)) u_dec (
    .cmd_i    (cmd),
    .field_i  (field_i),
    .bit_i    (bit_i),
    .flm_i    (flm_i),
    .l_i      (l_i),
    .w_i      (w_i),
    .imm_i    (imm_i),
    .src_i    (src_i),
    .ext_en_i (ext_en_i),
    .cur_i    (img_q),
    .wr_en_o  (wr_en),
    .fmask_o  (fmask),
    .fkeep_o  (fkeep),
    .bmask_o  (bmask),
    .wval_o   (wval),
    .rd_en_o  (rd_en),
    .rd_val_o (rd_val),
    .cr_en_o  (cr_en),
    .cr_val_o (cr_val),
    .inval_o  (inval)
  );

  fpsc_merge #(.NF(N_FLD), .IW(IMG_W)) u_mrg (
    .cur_i   (img_q),
    .wr_en_i (wr_en),
    .fmask_i (fmask),
    .fkeep_i (fkeep),
    .bmask_i (bmask),
    .wval_i  (wval),
    .nxt_o   (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img_q   <= '0;
      rd_q    <= '0;
      crf_q   <= '0;
      inval_q <= 1'b0;
    end else begin
      img_q   <= nxt;
      inval_q <= inval;
      if (rd_en) rd_q  <= rd_val;
      if (cr_en) crf_q <= cr_val;
    end
  end

  assign fpscr_o   = img_q[MAIN_W-1:0];
  assign rd_data_o = rd_q;
  assign crf_o     = crf_q;
  assign inval_o   = inval_q;

  // R11
  rd_all_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd6) |=> (img_q == $past(img_q)));

  // R8
  inval_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_q |-> (img_q == $past(img_q)));

  // R3
  bset_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd3 && bit_i inside {5'd1, 5'd2, 5'd29}) |=> (img_q == $past(img_q)));

  // R2
  fld2cr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd1) |=>
      (((img_q ^ $past(img_q)) & ~{32'h0, STICKY_M | SUMM_M}) == 64'h0));

  // R4
  fx_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd3 && bit_i inside {[5'd3:5'd12], [5'd21:5'd23]} &&
     !img_q[5'd31 - bit_i]) |=> img_q[B_FX]);

  // R10
  rn_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 4'd8 || cmd_i == 4'd9) |=>
      (((img_q ^ $past(img_q)) & ~64'h3) == 64'h0));
endmodule

// File: tb/fp_status_ctrl_bench.sv
module fp_status_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_r = '0;
  logic [2:0]  fld_r = '0;
  logic [4:0]  bit_r = '0;
  logic [7:0]  flm_r = '0;
  logic        l_r = 1'b0;
  logic        w_r = 1'b0;
  logic [3:0]  imm_r = '0;
  logic [63:0] src_r = '0;
  logic        ext_r = 1'b0;
  logic [31:0] fpscr;
  logic [63:0] rd_data;
  logic [3:0]  crf;
  logic        inval;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fp_status_ctrl u_fp_status_ctrl (
    .clk_i (clk), .rst_ni (rst_n), .cmd_i (cmd_r), .field_i (fld_r),
    .bit_i (bit_r), .flm_i (flm_r), .l_i (l_r), .w_i (w_r), .imm_i (imm_r),
    .src_i (src_r), .ext_en_i (ext_r), .fpscr_o (fpscr), .rd_data_o (rd_data),
    .crf_o (crf), .inval_o (inval)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c);
    @(negedge clk);
    cmd_r = c;
    @(negedge clk);
    cmd_r = 4'd0;
  endtask

  task automatic read_all(input string req, input logic [63:0] exp);
    issue(4'd6);
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 fpscr", {32'h0, fpscr}, 64'h0);
    chk("R1 rd", rd_data, 64'h0);
    chk("R1 crf", {60'h0, crf}, 64'h0);
    chk("R1 inval", {63'h0, inval}, 64'h0);
  endtask

  task automatic t_wide_write;
    ext_r = 0; l_r = 1; w_r = 0; src_r = 64'h0000_0005_FFFF_FFFF;
    issue(4'd4);
    chk("R7 l=1 base", {32'h0, fpscr}, 64'h0000_0000_FFFF_F7FF);
    read_all("R11 read", 64'h0000_0000_FFFF_F7FF);
    chk("R11 no change", {32'h0, fpscr}, 64'h0000_0000_FFFF_F7FF);
    issue(4'd0);
    chk("R11 rd holds", rd_data, 64'h0000_0000_FFFF_F7FF);
  endtask

  task automatic t_invalid;
    ext_r = 0; w_r = 1; fld_r = 3'd7; imm_r = 4'hF;
    issue(4'd5);
    chk("R8 inval imm", {63'h0, inval}, 64'h1);
    chk("R8 no change", {32'h0, fpscr}, 64'h0000_0000_FFFF_F7FF);
    @(negedge clk);
    chk("R8 pulse", {63'h0, inval}, 64'h0);
    l_r = 1; src_r = 64'h0;
    issue(4'd4);
    chk("R8 inval mask", {63'h0, inval}, 64'h1);
    read_all("R8 image kept", 64'h0000_0000_FFFF_F7FF);
    w_r = 0; l_r = 0;
  endtask

  task automatic t_ext_field;
    ext_r = 1; l_r = 0; w_r = 1; flm_r = 8'h01; src_r = 64'h0000_0006_0000_0000;
    issue(4'd4);
    read_all("R7 upper field", 64'h0000_0006_FFFF_F7FF);
    w_r = 0; ext_r = 0;
  endtask

  task automatic t_fld2cr;
    fld_r = 3'd0;
    issue(4'd1);
    chk("R2 crf top", {60'h0, crf}, 64'hF);
    chk("R2 clear sticky", {32'h0, fpscr}, 64'h6FFF_F7FF);
    fld_r = 3'd7;
    issue(4'd1);
    chk("R2 crf low", {60'h0, crf}, 64'hF);
    chk("R2 no sticky", {32'h0, fpscr}, 64'h6FFF_F7FF);
    fld_r = 3'd5;
    issue(4'd1);
    chk("R2 crf mid", {60'h0, crf}, 64'h7);
    chk("R2 clear mid", {32'h0, fpscr}, 64'h6FFF_F0FF);
  endtask

  task automatic t_clren;
    issue(4'd7);
    chk("R9 rd", rd_data, 64'h0000_0006_6FFF_F0FF);
    chk("R9 enables off", {32'h0, fpscr}, 64'h2FFF_F007);
  endtask

  task automatic t_rn;
    src_r = 64'hFFFF_FFFF_FFFF_FFF1;
    issue(4'd8);
    chk("R10 rd src", rd_data, 64'h0000_0006_0000_0007);
    chk("R10 rn src", {32'h0, fpscr}, 64'h2FFF_F005);
    imm_r = 4'hE;
    issue(4'd9);
    chk("R10 rd imm", rd_data, 64'h0000_0006_0000_0005);
    chk("R10 rn imm", {32'h0, fpscr}, 64'h2FFF_F006);
  endtask

  task automatic t_bitops;
    ext_r = 1; l_r = 1; src_r = 64'h0;
    issue(4'd4);
    read_all("R7 clear all", 64'h0);
    ext_r = 0; l_r = 0;
    bit_r = 5'd1; issue(4'd3);
    chk("R3 set FEX ignored", {32'h0, fpscr}, 64'h0);
    bit_r = 5'd29; issue(4'd3);
    chk("R3 set NI ignored", {32'h0, fpscr}, 64'h0);
    bit_r = 5'd2; issue(4'd3);
    chk("R3 set VX ignored", {32'h0, fpscr}, 64'h0);
    bit_r = 5'd30; issue(4'd3);
    chk("R3 set bit1", {32'h0, fpscr}, 64'h2);
    bit_r = 5'd24; issue(4'd3);
    chk("R3 set VE", {32'h0, fpscr}, 64'h82);
    bit_r = 5'd7; issue(4'd3);
    chk("R4 R5 set VXSNAN", {32'h0, fpscr}, 64'hE100_0082);
    bit_r = 5'd1; issue(4'd2);
    chk("R3 clr FEX ignored", {32'h0, fpscr}, 64'hE100_0082);
    bit_r = 5'd2; issue(4'd2);
    chk("R3 clr VX ignored", {32'h0, fpscr}, 64'hE100_0082);
    bit_r = 5'd7; issue(4'd2);
    chk("R5 summary drop", {32'h0, fpscr}, 64'h8000_0082);
    bit_r = 5'd0; issue(4'd2);
    chk("R3 clr FX", {32'h0, fpscr}, 64'h82);
  endtask

  task automatic t_imm;
    w_r = 0; fld_r = 3'd0; imm_r = 4'h1;
    issue(4'd5);
    chk("R4 OX via imm", {32'h0, fpscr}, 64'h9000_0082);
    imm_r = 4'h6;
    issue(4'd5);
    chk("R6 summary protected", {32'h0, fpscr}, 64'h82);
    ext_r = 1; w_r = 1; fld_r = 3'd7; imm_r = 4'hF;
    issue(4'd5);
    read_all("R6 upper imm", 64'h0000_0007_0000_0082);
    ext_r = 0; w_r = 0; fld_r = 3'd2;
    issue(4'd5);
    chk("R6 R5 field5", {32'h0, fpscr}, 64'hE0F0_0082);
  endtask

  task automatic t_mask_field;
    l_r = 0; w_r = 0; flm_r = 8'h01; src_r = 64'h1;
    issue(4'd4);
    chk("R7 field0", {32'h0, fpscr}, 64'hE0F0_0081);
    flm_r = 8'h04; src_r = 64'hF00;
    issue(4'd4);
    chk("R7 bit11 zero", {32'h0, fpscr}, 64'hE0F0_0781);
    read_all("R7 upper kept", 64'h0000_0007_E0F0_0781);
  endtask

  task automatic t_unknown;
    bit_r = 5'd0; fld_r = 3'd0; imm_r = 4'h0; src_r = 64'h0; l_r = 1; ext_r = 1;
    issue(4'hC);
    chk("R12 code 12", {32'h0, fpscr}, 64'hE0F0_0781);
    issue(4'hF);
    chk("R12 crf kept", {60'h0, crf}, 64'h7);
    read_all("R12 image kept", 64'h0000_0007_E0F0_0781);
    l_r = 0; ext_r = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_wide_write();
    t_invalid();
    t_ext_field();
    t_fld2cr();
    t_clren();
    t_rn();
    t_bitops();
    t_imm();
    t_mask_field();
    t_unknown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule